// File: doc/BRIEF.md
# Fast PWM Timer with Buffered Compare

This block is an 8-bit up-counting timer that drives a single waveform output in fast PWM fashion. A selectable prescaler turns the system clock into a timer tick, and the counter advances once per tick. A compare value from the bus first lands in a holding register. It reaches the active compare register only when the counter wraps, so a new duty cycle always starts on a period boundary and no period is ever cut short.

A 2-bit mode input sets what the waveform does. Mode 0 holds it low. Mode 1 toggles it on every compare match, and in this mode the counter turns around at the active compare value. Mode 2 gives non-inverted PWM and mode 3 gives inverted PWM. An overflow flag and a compare-match flag each stay set until their own clear input is pulsed.

Top module: `fpwm_timer`

## Requirements
- R1: While reset is asserted, and after it until the timer is started, the waveform output, the overflow flag and the compare flag are 0. The counter, the holding register and the active compare register reset to 0.
- R2: The prescaler select gives one counter step every 1, 8, 32, 64, 128, 256 or 1024 system clocks for codes 1 to 7 in that order. Code 0 stops the counter, so no flag sets and the waveform does not change.
- R3: In modes 0, 2 and 3 the counter steps from 0 up to 255 and then returns to 0, so one period is 256 counter steps.
- R4: The overflow flag sets on the tick that moves the counter off its top value (255, or the active compare value in mode 1). It then stays set until the overflow clear input is high at a clock edge. If a set and a clear happen on the same edge, the set wins.
- R5: The compare flag sets on the tick that moves the counter off a count equal to the active compare value. It then stays set until the compare clear input is high at a clock edge. If a set and a clear happen on the same edge, the set wins.
- R6: A bus write (write strobe high, data on the write data input) goes into the holding register. That value is copied into the active compare register only on the tick where the counter wraps. Before that, the current period keeps using the old value.
- R7: In mode 2 the output is high while the count is at or below the active compare value and low above it. A compare value of 0 gives a one-step high spike each period. A compare value of 255 gives a constant high.
- R8: In mode 3 the output is the inverse of mode 2. It is low while the count is at or below the compare value and high above it. A compare value of 255 gives a constant low.
- R9: In mode 1 the counter wraps to 0 after the count equal to the active compare value, and the output toggles on each of these steps. A compare value of 0 makes the output toggle on every tick, which is a 50% duty wave at half the tick rate.
- R10: In mode 0 the output is held low while the counter, the compare buffer and both flags keep running.
- R11: Any change of the prescaler select restarts the prescale count from zero. The first tick under the new select comes a full new division after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| presc_sel_i | input | 3 | Prescale code: 0 stop, 1..7 divide by 1, 8, 32, 64, 128, 256, 1024 |
| mode_i | input | 2 | Output mode: 0 off, 1 toggle, 2 PWM, 3 inverted PWM |
| cmp_wr_i | input | 1 | Write strobe for the compare holding register |
| cmp_wdata_i | input | 8 | Compare value to write |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| cmp_clr_i | input | 1 | Clears the compare flag |
| wave_o | output | 1 | Waveform output |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare-match flag |

## Verification
The bench targets the compare extremes.

- A compare value of 255 must give a steady level. A design that lets the match beat the wrap would produce a one-step glitch every period.
- A compare value of 0 must give a one-step spike. An off-by-one in the compare would make that spike vanish or double.

The write timing is checked by writing mid-period. A design without the buffer changes the duty cycle inside the running period, and the bench catches this at the counts between the old and new values.

The prescaler checks do two things:
- They measure the tick spacing for every select code. A wrong divider moves the flag edge.
- They change the select mid-count. A prescaler that does not restart fires its first tick early.

Flag races are checked by pulsing a clear on the very edge that sets the flag. A design where the clear wins loses the event.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    localparam int PSEL_W = 3;

    typedef enum logic [1:0] {
        WAVE_OFF     = 2'd0,
        WAVE_TOGGLE  = 2'd1,
        WAVE_PWM     = 2'd2,
        WAVE_PWM_INV = 2'd3
    } wave_mode_e;

    // log2 of the clock division picked by a prescale code
    function automatic int unsigned div_log2(input logic [PSEL_W-1:0] sel);
        int unsigned r;
        case (sel)
            3'd1:    r = 0;
            3'd2:    r = 3;
            3'd3:    r = 5;
            3'd4:    r = 6;
            3'd5:    r = 7;
            3'd6:    r = 8;
            3'd7:    r = 10;
            default: r = 0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler
    import fpwm_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PSEL_W-1:0] sel_i,
    output logic              tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic [PSEL_W-1:0] sel;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [DIV_W-1:0] lim_m1;
    logic run, tick;

    always_comb begin
        st_d   = st_q;
        lim_m1 = DIV_W'((32'd1 << div_log2(st_q.sel)) - 32'd1);
        run    = (sel_i == st_q.sel) && (st_q.sel != '0);
        tick   = run && (st_q.cnt == lim_m1);
        if (sel_i != st_q.sel) begin
            // new division: restart the count
            st_d.sel = sel_i;
            st_d.cnt = '0;
        end else if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = tick;

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] act_o,
    output logic             wrap_o,
    output logic             match_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pend;
        logic [CNT_W-1:0] act;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] top;
    logic at_end, wrap, match;

    always_comb begin
        st_d   = st_q;
        top    = (wave_mode_e'(mode_i) == WAVE_TOGGLE) ? st_q.act : CNT_MAX;
        // the natural roll at MAX also ends a period if the count ran past top
        at_end = (st_q.cnt == top) || (st_q.cnt == CNT_MAX);
        wrap   = tick_i && at_end;
        match  = tick_i && (st_q.cnt == st_q.act);
        if (tick_i) st_d.cnt = at_end ? '0 : st_q.cnt + CNT_W'(1);
        if (wr_i)   st_d.pend = wdata_i;
        if (wrap)   st_d.act  = st_q.pend;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign act_o   = st_q.act;
    assign wrap_o  = wrap;
    assign match_o = match;

endmodule

// File: rtl/fpwm_wave.sv
module fpwm_wave
    import fpwm_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       wrap_i,
    input  logic       match_i,
    input  logic       ovf_clr_i,
    input  logic       cmp_clr_i,
    output logic       wave_o,
    output logic       ovf_o,
    output logic       cmp_o
);

    typedef struct packed {
        logic wave;
        logic ovf;
        logic cmp;
    } wave_state_t;

    wave_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (wave_mode_e'(mode_i))
            WAVE_OFF:     st_d.wave = 1'b0;
            WAVE_TOGGLE:  st_d.wave = match_i ? ~st_q.wave : st_q.wave;
            // wrap beats match so that compare==MAX holds a steady level
            WAVE_PWM:     st_d.wave = wrap_i ? 1'b1 : (match_i ? 1'b0 : st_q.wave);
            WAVE_PWM_INV: st_d.wave = wrap_i ? 1'b0 : (match_i ? 1'b1 : st_q.wave);
            default:      st_d.wave = 1'b0;
        endcase
        if (wrap_i)         st_d.ovf = 1'b1;
        else if (ovf_clr_i) st_d.ovf = 1'b0;
        if (match_i)        st_d.cmp = 1'b1;
        else if (cmp_clr_i) st_d.cmp = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign wave_o = st_q.wave;
    assign ovf_o  = st_q.ovf;
    assign cmp_o  = st_q.cmp;

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PSEL_W-1:0] presc_sel_i,
    input  logic [1:0]        mode_i,
    input  logic              cmp_wr_i,
    input  logic [CNT_W-1:0]  cmp_wdata_i,
    input  logic              ovf_clr_i,
    input  logic              cmp_clr_i,
    output logic              wave_o,
    output logic              ovf_flag_o,
    output logic              cmp_flag_o
);

    logic             tick;
    logic             wrap;
    logic             match;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cmp_act;

    fpwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (presc_sel_i),
        .tick_o (tick)
    );

    fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .mode_i  (mode_i),
        .wr_i    (cmp_wr_i),
        .wdata_i (cmp_wdata_i),
        .cnt_o   (cnt_val),
        .act_o   (cmp_act),
        .wrap_o  (wrap),
        .match_o (match)
    );

    fpwm_wave u_wave (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode_i),
        .wrap_i    (wrap),
        .match_i   (match),
        .ovf_clr_i (ovf_clr_i),
        .cmp_clr_i (cmp_clr_i),
        .wave_o    (wave_o),
        .ovf_o     (ovf_flag_o),
        .cmp_o     (cmp_flag_o)
    );

endmodule

// File: rtl/fpwm_checker.sv
module fpwm_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [2:0]       presc_sel_i,
    input logic [1:0]       mode_i,
    input logic             ovf_clr_i,
    input logic             cmp_clr_i,
    input logic             wave_o,
    input logic             ovf_flag_o,
    input logic             cmp_flag_o,
    input logic             tick_i,
    input logic             wrap_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] act_i
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r4_ovf_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

    a_r5_cmp_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_flag_o && !cmp_clr_i) |=> cmp_flag_o);

    a_r2_stop_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (presc_sel_i == 3'd0) |=> $stable(cnt_i));

    a_r3_roll_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && cnt_i == CNT_MAX) |=> (cnt_i == '0));

    a_r6_act_only_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap_i |=> $stable(act_i));

    a_r7_pwm_high_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && mode_i == 2'd2) |=> wave_o);

    a_r8_inv_low_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && mode_i == 2'd3) |=> !wave_o);

    a_r10_off_is_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd0) |=> !wave_o);

endmodule

bind fpwm_timer fpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .presc_sel_i (presc_sel_i),
    .mode_i      (mode_i),
    .ovf_clr_i   (ovf_clr_i),
    .cmp_clr_i   (cmp_clr_i),
    .wave_o      (wave_o),
    .ovf_flag_o  (ovf_flag_o),
    .cmp_flag_o  (cmp_flag_o),
    .tick_i      (tick),
    .wrap_i      (wrap),
    .cnt_i       (cnt_val),
    .act_i       (cmp_act)
);

// File: tb/test_fpwm_timer.sv
`timescale 1ns/1ps
module test_fpwm_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] sel;
    logic [1:0] mode;
    logic       cmp_wr;
    logic [7:0] cmp_wdata;
    logic       ovf_clr;
    logic       cmp_clr;
    logic       wave;
    logic       ovf;
    logic       cmpf;

    int total = 0;
    int bad   = 0;
    int unsigned cyc = 0;

    typedef struct {
        int unsigned cyc;
        bit          exp;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpwm_timer i_fpwm_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .presc_sel_i (sel),
        .mode_i      (mode),
        .cmp_wr_i    (cmp_wr),
        .cmp_wdata_i (cmp_wdata),
        .ovf_clr_i   (ovf_clr),
        .cmp_clr_i   (cmp_clr),
        .wave_o      (wave),
        .ovf_flag_o  (ovf),
        .cmp_flag_o  (cmpf)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: pops scoreboard items due in this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc == cyc) begin
            exp_t it;
            it = sb.pop_front();
            check(it.req, int'(wave), int'(it.exp));
        end
    end

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmp(input int v);
        cmp_wdata = 8'(v);
        cmp_wr    = 1'b1;
        step(1);
        cmp_wr    = 1'b0;
    endtask

    // returns at the negedge right after a counter wrap (k = 0)
    task automatic sync_wrap();
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        while (!ovf) step(1);
    endtask

    // driver: pushes expected waveform values for the coming cycles
    task automatic run_pwm(input string req, input logic [1:0] m, input int o,
                           input logic [2:0] s, input int n_div, input int len);
        int unsigned base;
        bit w0;
        mode = m;
        sel  = s;
        write_cmp(o);
        sync_wrap();
        sync_wrap();
        base = cyc;
        w0   = wave;
        if (m == 2'd2) check(req, int'(wave), 1);
        if (m == 2'd3) check(req, int'(wave), 0);
        if (m == 2'd0) check(req, int'(wave), 0);
        for (int k = 1; k <= len; k++) begin
            int c;
            exp_t it;
            c = (k / n_div) % 256;
            case (m)
                2'd2:    it.exp = (c <= o);
                2'd3:    it.exp = !(c <= o);
                2'd1:    it.exp = w0 ^ bit'(((k / n_div) / (o + 1)) % 2);
                default: it.exp = 1'b0;
            endcase
            it.cyc = base + k;
            it.req = req;
            sb.push_back(it);
        end
        step(len);
    endtask

    initial begin
        rst_n = 1'b0; sel = 3'd0; mode = 2'd0; cmp_wr = 1'b0;
        cmp_wdata = 8'd0; ovf_clr = 1'b0; cmp_clr = 1'b0;
        step(4);
        check("R1", int'(wave), 0);
        check("R1", int'(ovf), 0);
        check("R1", int'(cmpf), 0);
        rst_n = 1'b1;
        step(20);
        check("R1", int'(wave), 0);
        check("R1", int'(ovf), 0);
        check("R1", int'(cmpf), 0);

        // waveform shapes, tick every clock
        run_pwm("R7", 2'd2, 100, 3'd1, 1, 600);
        run_pwm("R7", 2'd2, 0,   3'd1, 1, 600);
        run_pwm("R7", 2'd2, 255, 3'd1, 1, 600);
        run_pwm("R8", 2'd3, 100, 3'd1, 1, 600);
        run_pwm("R8", 2'd3, 0,   3'd1, 1, 600);
        run_pwm("R8", 2'd3, 255, 3'd1, 1, 600);
        run_pwm("R10", 2'd0, 100, 3'd1, 1, 600);
        check("R10", int'(ovf), 1);
        run_pwm("R9", 2'd1, 5, 3'd1, 1, 300);
        run_pwm("R9", 2'd1, 0, 3'd1, 1, 300);
        run_pwm("R2", 2'd2, 30, 3'd2, 8, 2100);

        // flags: hold, clear, set beats clear, period of 256
        mode = 2'd2; sel = 3'd1;
        write_cmp(100);
        sync_wrap();
        sync_wrap();
        ovf_clr = 1'b1; cmp_clr = 1'b1;
        step(1);                                      // k=1
        ovf_clr = 1'b0; cmp_clr = 1'b0;
        check("R4", int'(ovf), 0);
        check("R5", int'(cmpf), 0);
        step(99);                                     // k=100
        check("R5", int'(cmpf), 0);
        step(1);                                      // k=101
        check("R5", int'(cmpf), 1);
        cmp_clr = 1'b1;
        step(1);                                      // k=102
        cmp_clr = 1'b0;
        check("R5", int'(cmpf), 0);
        step(153);                                    // k=255
        check("R3", int'(ovf), 0);
        ovf_clr = 1'b1;
        step(1);                                      // k=256
        ovf_clr = 1'b0;
        check("R4", int'(ovf), 1);
        check("R3", int'(ovf), 1);
        step(44);                                     // k=300
        check("R4", int'(ovf), 1);

        // double buffer: mid-period write waits for the wrap
        write_cmp(50);
        sync_wrap();
        sync_wrap();                                  // k=0
        step(10);                                     // k=10
        cmp_wdata = 8'd200; cmp_wr = 1'b1;
        step(1);                                      // k=11
        cmp_wr = 1'b0;
        step(49);                                     // k=60
        check("R6", int'(wave), 0);
        step(296);                                    // k=356
        check("R6", int'(wave), 1);
        step(100);                                    // k=456
        check("R6", int'(wave), 1);
        step(1);                                      // k=457
        check("R6", int'(wave), 0);

        // prescaler sweep: toggle mode, compare 0 -> one wrap per tick
        mode = 2'd1; sel = 3'd1;
        write_cmp(0);
        sync_wrap();
        sync_wrap();
        for (int s = 1; s <= 7; s++) begin
            int n;
            case (s)
                1: n = 1;   2: n = 8;   3: n = 32;  4: n = 64;
                5: n = 128; 6: n = 256; default: n = 1024;
            endcase
            sel = 3'(s);
            sync_wrap();                              // k=0
            ovf_clr = 1'b1;
            step(1);                                  // k=1
            ovf_clr = 1'b0;
            if (n == 1) begin
                check("R2", int'(ovf), 1);
            end else begin
                step(n - 2);                          // k=n-1
                check("R2", int'(ovf), 0);
                step(1);                              // k=n
                check("R2", int'(ovf), 1);
            end
        end

        // select change restarts the prescale count
        sel = 3'd3;
        sync_wrap();                                  // k=0
        ovf_clr = 1'b1;
        step(1);                                      // k=1
        ovf_clr = 1'b0;
        step(9);                                      // k=10
        sel = 3'd4;
        step(64);                                     // k=74
        check("R11", int'(ovf), 0);
        step(1);                                      // k=75
        check("R11", int'(ovf), 1);

        // stop code freezes the timer
        sel = 3'd0;
        step(2);
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        begin
            bit w;
            w = wave;
            step(2000);
            check("R2", int'(ovf), 0);
            check("R2", int'(wave), int'(w));
        end

        finish_up();
    end

endmodule